// File: doc/BRIEF.md
# Transaction ID Remapping Table

This block stands between an internal interconnect and an external peripheral network. Commands from the internal side are tagged with a requester identifier (SRCID) and a thread identifier (TRDID). On the way out, the block records that pair in a small table. It then sends the command with the bridge's own external SRCID and with the table index as TRDID. Responses from the peripherals can therefore only come back through this bridge.

When a response flit arrives, its RTRDID selects a table entry. The block restores the original SRCID and TRDID from that entry and forwards the flit to the internal side through a one-flit output register. The entry is released on the last flit of the response. Commands are single-flit packets. Responses may be several flits long, and the last one carries EOP.

When every entry is in use, new commands are held off. Two counters keep statistics on this: one counts stall episodes and the other counts stalled cycles. A response that names an unused entry is discarded, and a sticky flag records it.

Top module: `tidr_remap_table`

## Requirements
- R1: After reset every entry is free, `int_rsp_valid` is low, both stall counters read 0 and `rsp_err` is low, so a command offered with `out_cmd_ready` high is accepted at once.
- R2: While the table is not full, a command passes through combinationally. `out_cmd_valid` follows `in_cmd_valid` and `in_cmd_ready` follows `out_cmd_ready`. `out_cmd_srcid` equals the parameter OWN_SRCID (default 8'h3C), `out_cmd_trdid` equals the allocated entry index zero-extended to 4 bits, and the payload is unchanged.
- R3: Each accepted command takes the free entry with the lowest index.
- R4: While all entries are occupied, `in_cmd_ready` and `out_cmd_valid` are low. `stall_cycles` increments on every cycle in which `in_cmd_valid` is high with the table full. `stall_events` increments once per episode, on the first such cycle that follows a cycle that was not one.
- R5: A response flit accepted on the external side (`ext_rsp_valid` and `ext_rsp_ready` high at a clock edge) appears on `int_rsp_*` after that edge. It carries the SRCID and TRDID stored in the entry chosen by `ext_rsp_trdid`, with the data and EOP unchanged. The flit is held until `int_rsp_ready`, and while it is held with `int_rsp_ready` low, `ext_rsp_ready` is low for flits that name valid entries.
- R6: An entry is released only when a response flit with EOP set is accepted. Flits without EOP leave it occupied.
- R7: An allocation and a release in the same cycle both take effect. The command takes the lowest entry that was free before that edge, and the released entry is free after it.
- R8: A response flit whose `ext_rsp_trdid` names a free entry, or an index of ENTRIES or above, is accepted with `ext_rsp_ready` high and produces no output flit. It sets `rsp_err`, which stays high until reset.
- R9: The restored identifiers of a pending output flit are held in their own register and stay unchanged even if the entry they came from is reallocated to a new command while the flit waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_cmd_valid | input | 1 | Internal-side command valid |
| in_cmd_ready | output | 1 | Internal-side command ready |
| in_cmd_srcid | input | 8 | Requester SRCID of the command |
| in_cmd_trdid | input | 4 | Requester TRDID of the command |
| in_cmd_payload | input | 16 | Command payload |
| out_cmd_valid | output | 1 | External-side command valid |
| out_cmd_ready | input | 1 | External-side command ready |
| out_cmd_srcid | output | 8 | Bridge's own external SRCID |
| out_cmd_trdid | output | 4 | Allocated entry index |
| out_cmd_payload | output | 16 | Command payload, unchanged |
| ext_rsp_valid | input | 1 | External response flit valid |
| ext_rsp_ready | output | 1 | External response flit ready |
| ext_rsp_trdid | input | 4 | Returned RTRDID, an entry index |
| ext_rsp_data | input | 16 | Response data |
| ext_rsp_eop | input | 1 | Last flit of the response |
| int_rsp_valid | output | 1 | Internal response flit valid |
| int_rsp_ready | input | 1 | Internal response flit ready |
| int_rsp_srcid | output | 8 | Restored SRCID |
| int_rsp_trdid | output | 4 | Restored TRDID |
| int_rsp_data | output | 16 | Response data |
| int_rsp_eop | output | 1 | Last flit of the response |
| stall_events | output | 16 | Number of full-table stall episodes |
| stall_cycles | output | 16 | Number of cycles stalled on a full table |
| rsp_err | output | 1 | Sticky flag for a response to an unused entry |

## Verification
The hardest case to reach is a pending output flit whose source entry has already been released and handed to a new command. That case tests R9, and it needs the internal side to apply backpressure at the moment a final flit is accepted. The stimulus fills the table and lowers `int_rsp_ready`. It then sends an EOP flit for entry 1 and, in the next cycle, a new command that must take entry 1. While the old flit is still held, the bench checks its restored identifiers and checks that a further response flit is refused. The same-cycle allocation and release of R7 is reached by presenting a command and a final response flit on the same clock edge.

// File: rtl/tidr_pkg.sv
package tidr_pkg;
    localparam int SRCID_W = 8;
    localparam int TRDID_W = 4;
    localparam int PAY_W   = 16;
    localparam int DATA_W  = 16;

    typedef logic [SRCID_W-1:0] srcid_t;
    typedef logic [TRDID_W-1:0] trdid_t;

    typedef struct packed {
        srcid_t srcid;
        trdid_t trdid;
    } id_pair_t;

    typedef struct packed {
        id_pair_t          ids;
        logic [DATA_W-1:0] data;
        logic              eop;
    } rsp_flit_t;

    function automatic trdid_t widen_index(input logic [31:0] idx);
        return trdid_t'(idx);
    endfunction
endpackage

// File: rtl/tidr_alloc.sv
module tidr_alloc #(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc_en,
    input  logic               free_en,
    input  logic [IDX_W-1:0]   free_idx,
    output logic [ENTRIES-1:0] vld,
    output logic [IDX_W-1:0]   alloc_idx,
    output logic               full
);
    logic [ENTRIES-1:0] alloc_mask;
    logic [ENTRIES-1:0] free_mask;

    // lowest free index wins: scan downward so the last hit is the lowest
    always_comb begin
        alloc_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) alloc_idx = IDX_W'(i);
        end
    end

    assign full = &vld;

    always_comb begin
        alloc_mask = '0;
        free_mask  = '0;
        if (alloc_en) alloc_mask[alloc_idx] = 1'b1;
        if (free_en)  free_mask[free_idx]   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) vld <= '0;
        else     vld <= (vld & ~free_mask) | alloc_mask;
    end
endmodule

// File: rtl/tidr_store.sv
module tidr_store
    import tidr_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  id_pair_t         wr_ids,
    input  logic [IDX_W-1:0] rd_idx,
    output id_pair_t         rd_ids
);
    id_pair_t mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_ids;
    end

    assign rd_ids = mem[rd_idx];
endmodule

// File: rtl/tidr_rsp_stage.sv
module tidr_rsp_stage
    import tidr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  rsp_flit_t load_flit,
    output logic      can_load,
    output logic      out_valid,
    input  logic      out_ready,
    output rsp_flit_t out_flit
);
    rsp_flit_t hold_q;
    logic      valid_q;

    assign can_load  = !valid_q || out_ready;
    assign out_valid = valid_q;
    assign out_flit  = hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            hold_q  <= '0;
        end else if (can_load) begin
            valid_q <= load;
            if (load) hold_q <= load_flit;
        end
    end
endmodule

// File: rtl/tidr_stall_mon.sv
module tidr_stall_mon #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stalled,
    output logic [CNT_W-1:0] events,
    output logic [CNT_W-1:0] cycles
);
    logic stalled_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stalled_q <= 1'b0;
            events    <= '0;
            cycles    <= '0;
        end else begin
            stalled_q <= stalled;
            if (stalled)               cycles <= cycles + 1'b1;
            if (stalled && !stalled_q) events <= events + 1'b1;
        end
    end
endmodule

// File: rtl/tidr_remap_table.sv
module tidr_remap_table
    import tidr_pkg::*;
#(
    parameter int     ENTRIES   = 4,
    parameter int     CNT_W     = 16,
    parameter srcid_t OWN_SRCID = 8'h3C,
    localparam int    IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_cmd_valid,
    output logic              in_cmd_ready,
    input  logic [SRCID_W-1:0] in_cmd_srcid,
    input  logic [TRDID_W-1:0] in_cmd_trdid,
    input  logic [PAY_W-1:0]   in_cmd_payload,
    output logic              out_cmd_valid,
    input  logic              out_cmd_ready,
    output logic [SRCID_W-1:0] out_cmd_srcid,
    output logic [TRDID_W-1:0] out_cmd_trdid,
    output logic [PAY_W-1:0]   out_cmd_payload,
    input  logic              ext_rsp_valid,
    output logic              ext_rsp_ready,
    input  logic [TRDID_W-1:0] ext_rsp_trdid,
    input  logic [DATA_W-1:0]  ext_rsp_data,
    input  logic              ext_rsp_eop,
    output logic              int_rsp_valid,
    input  logic              int_rsp_ready,
    output logic [SRCID_W-1:0] int_rsp_srcid,
    output logic [TRDID_W-1:0] int_rsp_trdid,
    output logic [DATA_W-1:0]  int_rsp_data,
    output logic              int_rsp_eop,
    output logic [CNT_W-1:0]   stall_events,
    output logic [CNT_W-1:0]   stall_cycles,
    output logic              rsp_err
);
    logic [ENTRIES-1:0] vld;
    logic [IDX_W-1:0]   alloc_idx;
    logic               full;
    logic               cmd_fire;
    logic [IDX_W-1:0]   rsp_idx;
    logic               rsp_hit;
    logic               can_load;
    logic               rsp_accept;
    id_pair_t           looked_up;
    rsp_flit_t          load_flit;
    rsp_flit_t          held_flit;

    // command side
    assign out_cmd_valid   = in_cmd_valid && !full;
    assign in_cmd_ready    = out_cmd_ready && !full;
    assign cmd_fire        = in_cmd_valid && in_cmd_ready;
    assign out_cmd_srcid   = OWN_SRCID;
    assign out_cmd_trdid   = widen_index(32'(alloc_idx));
    assign out_cmd_payload = in_cmd_payload;

    // response side lookup
    assign rsp_idx    = ext_rsp_trdid[IDX_W-1:0];
    assign rsp_hit    = (32'(ext_rsp_trdid) < ENTRIES) && vld[rsp_idx];
    assign rsp_accept = ext_rsp_valid && rsp_hit && can_load;
    assign ext_rsp_ready = rsp_hit ? can_load : 1'b1;

    assign load_flit.ids  = looked_up;
    assign load_flit.data = ext_rsp_data;
    assign load_flit.eop  = ext_rsp_eop;

    tidr_alloc #(.ENTRIES(ENTRIES)) alloc_i (
        .clk       (clk),
        .rst       (rst),
        .alloc_en  (cmd_fire),
        .free_en   (rsp_accept && ext_rsp_eop),
        .free_idx  (rsp_idx),
        .vld       (vld),
        .alloc_idx (alloc_idx),
        .full      (full)
    );

    tidr_store #(.ENTRIES(ENTRIES)) store_i (
        .clk    (clk),
        .wr_en  (cmd_fire),
        .wr_idx (alloc_idx),
        .wr_ids ('{srcid: in_cmd_srcid, trdid: in_cmd_trdid}),
        .rd_idx (rsp_idx),
        .rd_ids (looked_up)
    );

    tidr_rsp_stage rsp_i (
        .clk       (clk),
        .rst       (rst),
        .load      (rsp_accept),
        .load_flit (load_flit),
        .can_load  (can_load),
        .out_valid (int_rsp_valid),
        .out_ready (int_rsp_ready),
        .out_flit  (held_flit)
    );

    assign int_rsp_srcid = held_flit.ids.srcid;
    assign int_rsp_trdid = held_flit.ids.trdid;
    assign int_rsp_data  = held_flit.data;
    assign int_rsp_eop   = held_flit.eop;

    tidr_stall_mon #(.CNT_W(CNT_W)) mon_i (
        .clk     (clk),
        .rst     (rst),
        .stalled (in_cmd_valid && full),
        .events  (stall_events),
        .cycles  (stall_cycles)
    );

    always_ff @(posedge clk) begin
        if (rst)                           rsp_err <= 1'b0;
        else if (ext_rsp_valid && !rsp_hit) rsp_err <= 1'b1;
    end
endmodule

// File: rtl/tidr_remap_table_chk.sv
module tidr_remap_table_chk
    import tidr_pkg::*;
#(
    parameter int  ENTRIES = 4,
    parameter int  CNT_W   = 16,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic [ENTRIES-1:0] vld,
    input logic               in_cmd_valid,
    input logic               in_cmd_ready,
    input logic [TRDID_W-1:0] out_cmd_trdid,
    input logic               ext_rsp_valid,
    input logic               ext_rsp_ready,
    input logic [TRDID_W-1:0] ext_rsp_trdid,
    input logic               ext_rsp_eop,
    input logic               int_rsp_valid,
    input logic               int_rsp_ready,
    input logic [SRCID_W-1:0] int_rsp_srcid,
    input logic [TRDID_W-1:0] int_rsp_trdid,
    input logic [CNT_W-1:0]   stall_cycles,
    input logic               rsp_err
);
    p_full_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        (&vld) |-> !in_cmd_ready);

    p_stall_count_r4: assert property (@(posedge clk) disable iff (rst)
        (in_cmd_valid && (&vld)) |=> stall_cycles == $past(stall_cycles) + 1'b1);

    p_alloc_free_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (in_cmd_valid && in_cmd_ready) |-> !vld[out_cmd_trdid[IDX_W-1:0]]);

    p_alloc_marks_r7: assert property (@(posedge clk) disable iff (rst)
        (in_cmd_valid && in_cmd_ready) |=> vld[$past(out_cmd_trdid[IDX_W-1:0])]);

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (int_rsp_valid && !int_rsp_ready) |=>
            int_rsp_valid && $stable(int_rsp_srcid) && $stable(int_rsp_trdid));

    p_nonlast_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (ext_rsp_valid && ext_rsp_ready && !ext_rsp_eop && !rsp_err &&
         (32'(ext_rsp_trdid) < ENTRIES) && vld[ext_rsp_trdid[IDX_W-1:0]])
            |=> vld[$past(ext_rsp_trdid[IDX_W-1:0])]);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_err |=> rsp_err);
endmodule

bind tidr_remap_table tidr_remap_table_chk #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .vld           (vld),
    .in_cmd_valid  (in_cmd_valid),
    .in_cmd_ready  (in_cmd_ready),
    .out_cmd_trdid (out_cmd_trdid),
    .ext_rsp_valid (ext_rsp_valid),
    .ext_rsp_ready (ext_rsp_ready),
    .ext_rsp_trdid (ext_rsp_trdid),
    .ext_rsp_eop   (ext_rsp_eop),
    .int_rsp_valid (int_rsp_valid),
    .int_rsp_ready (int_rsp_ready),
    .int_rsp_srcid (int_rsp_srcid),
    .int_rsp_trdid (int_rsp_trdid),
    .stall_cycles  (stall_cycles),
    .rsp_err       (rsp_err)
);

// File: tb/tidr_remap_table_tb.sv
module tidr_remap_table_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] OWN = 8'h3C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_cmd_valid = 1'b0;
    logic        in_cmd_ready;
    logic [7:0]  in_cmd_srcid = '0;
    logic [3:0]  in_cmd_trdid = '0;
    logic [15:0] in_cmd_payload = '0;
    logic        out_cmd_valid;
    logic        out_cmd_ready = 1'b1;
    logic [7:0]  out_cmd_srcid;
    logic [3:0]  out_cmd_trdid;
    logic [15:0] out_cmd_payload;
    logic        ext_rsp_valid = 1'b0;
    logic        ext_rsp_ready;
    logic [3:0]  ext_rsp_trdid = '0;
    logic [15:0] ext_rsp_data = '0;
    logic        ext_rsp_eop = 1'b0;
    logic        int_rsp_valid;
    logic        int_rsp_ready = 1'b1;
    logic [7:0]  int_rsp_srcid;
    logic [3:0]  int_rsp_trdid;
    logic [15:0] int_rsp_data;
    logic        int_rsp_eop;
    logic [15:0] stall_events;
    logic [15:0] stall_cycles;
    logic        rsp_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    tidr_remap_table dut_i (.*);

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    logic [7:0]  m_src [4];
    logic [3:0]  m_trd [4];
    logic [28:0] exp_q [$];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    task automatic do_cmd(input logic [7:0] s, input logic [3:0] t,
                          input logic [15:0] p, input int exp_idx, input string req);
        in_cmd_valid = 1; in_cmd_srcid = s; in_cmd_trdid = t; in_cmd_payload = p;
        #1;
        chk(req, "cmd ready", 32'(in_cmd_ready), 1);
        chk(req, "cmd valid out", 32'(out_cmd_valid), 1);
        chk(req, "out srcid", 32'(out_cmd_srcid), 32'(OWN));
        chk(req, "out trdid", 32'(out_cmd_trdid), exp_idx);
        chk(req, "payload", 32'(out_cmd_payload), 32'(p));
        m_src[exp_idx] = s; m_trd[exp_idx] = t;
        tick;
        in_cmd_valid = 0;
    endtask

    task automatic do_rsp(input int idx, input logic [15:0] d, input logic e);
        ext_rsp_valid = 1; ext_rsp_trdid = 4'(idx); ext_rsp_data = d; ext_rsp_eop = e;
        exp_q.push_back({m_src[idx], m_trd[idx], d, e});
        #1;
        while (!ext_rsp_ready) tick;
        tick;
        ext_rsp_valid = 0;
    endtask

    // scoreboard monitor: a handshake seen here completes at the next edge
    always begin
        @(negedge clk);
        #3;
        if (!rst && int_rsp_valid && int_rsp_ready) begin
            if (exp_q.size() == 0) begin
                chk("R5", "unexpected rsp flit", 32'(int_rsp_data), 32'hDEAD);
            end else begin
                logic [28:0] e;
                e = exp_q.pop_front();
                chk("R5", "rsp srcid", 32'(int_rsp_srcid), 32'(e[28:21]));
                chk("R5", "rsp trdid", 32'(int_rsp_trdid), 32'(e[20:17]));
                chk("R5", "rsp data",  32'(int_rsp_data),  32'(e[16:1]));
                chk("R5", "rsp eop",   32'(int_rsp_eop),   32'(e[0]));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run;
    end

    initial begin
        tick; tick;
        rst = 0;
        tick;
        // R1 reset state
        chk("R1", "rsp valid", 32'(int_rsp_valid), 0);
        chk("R1", "events", 32'(stall_events), 0);
        chk("R1", "cycles", 32'(stall_cycles), 0);
        chk("R1", "err", 32'(rsp_err), 0);
        chk("R1", "cmd ready", 32'(in_cmd_ready), 1);

        // R2/R3 fill the table, lowest index first
        do_cmd(8'h11, 4'h7, 16'h1000, 0, "R3");
        do_cmd(8'h22, 4'h6, 16'h2001, 1, "R2");
        do_cmd(8'h33, 4'h5, 16'h3002, 2, "R3");
        do_cmd(8'h44, 4'h4, 16'h4003, 3, "R2");

        // R4 full: blocked, two stall episodes (3 then 2 cycles)
        in_cmd_valid = 1; in_cmd_srcid = 8'h55;
        #1;
        chk("R4", "ready when full", 32'(in_cmd_ready), 0);
        chk("R4", "out valid when full", 32'(out_cmd_valid), 0);
        tick; tick; tick;
        in_cmd_valid = 0;
        tick;
        in_cmd_valid = 1;
        tick; tick;
        in_cmd_valid = 0;
        chk("R4", "stall cycles", 32'(stall_cycles), 5);
        chk("R4", "stall events", 32'(stall_events), 2);

        // R6 non-last flit keeps entry 2 occupied
        do_rsp(2, 16'hA0A0, 1'b0);
        in_cmd_valid = 1;
        #1;
        chk("R6", "still full after non-eop", 32'(in_cmd_ready), 0);
        in_cmd_valid = 0;
        do_rsp(2, 16'hA1A1, 1'b1);
        tick;
        do_cmd(8'h66, 4'h3, 16'h5004, 2, "R6");

        // R5/R9 backpressure, entry reallocated while its flit waits
        int_rsp_ready = 0;
        ext_rsp_valid = 1; ext_rsp_trdid = 4'd1; ext_rsp_data = 16'hB1B1; ext_rsp_eop = 1;
        exp_q.push_back({m_src[1], m_trd[1], 16'hB1B1, 1'b1});
        tick;
        ext_rsp_valid = 0;
        #1;
        chk("R5", "held flit valid", 32'(int_rsp_valid), 1);
        do_cmd(8'h77, 4'h2, 16'h6005, 1, "R9");
        chk("R9", "held srcid", 32'(int_rsp_srcid), 32'h22);
        chk("R9", "held trdid", 32'(int_rsp_trdid), 32'h6);
        ext_rsp_valid = 1; ext_rsp_trdid = 4'd3; ext_rsp_eop = 0;
        #1;
        chk("R5", "ext ready while held", 32'(ext_rsp_ready), 0);
        tick;
        ext_rsp_valid = 0;
        int_rsp_ready = 1;
        tick;

        // R8 responses to a free entry and to an out-of-range index
        do_rsp(0, 16'hC0C0, 1'b1);
        tick;
        chk("R8", "err before", 32'(rsp_err), 0);
        ext_rsp_valid = 1; ext_rsp_trdid = 4'd0; ext_rsp_data = 16'hEEEE; ext_rsp_eop = 1;
        #1;
        chk("R8", "ready on drop", 32'(ext_rsp_ready), 1);
        tick;
        ext_rsp_trdid = 4'd15;
        #1;
        chk("R8", "ready on range drop", 32'(ext_rsp_ready), 1);
        chk("R8", "no flit after drop", 32'(int_rsp_valid), 0);
        chk("R8", "err set", 32'(rsp_err), 1);
        tick;
        ext_rsp_valid = 0;
        #1;
        chk("R8", "no flit after range drop", 32'(int_rsp_valid), 0);

        // R7 allocate entry 0 and release entry 3 on the same edge
        in_cmd_valid = 1; in_cmd_srcid = 8'h88; in_cmd_trdid = 4'h1; in_cmd_payload = 16'h7006;
        ext_rsp_valid = 1; ext_rsp_trdid = 4'd3; ext_rsp_data = 16'hD3D3; ext_rsp_eop = 1;
        exp_q.push_back({m_src[3], m_trd[3], 16'hD3D3, 1'b1});
        #1;
        chk("R7", "alloc idx", 32'(out_cmd_trdid), 0);
        chk("R7", "rsp ready", 32'(ext_rsp_ready), 1);
        m_src[0] = 8'h88; m_trd[0] = 4'h1;
        tick;
        in_cmd_valid = 0; ext_rsp_valid = 0;
        do_cmd(8'h99, 4'h0, 16'h8007, 3, "R7");
        tick; tick;
        chk("R5", "scoreboard drained", 32'(exp_q.size()), 0);
        chk("R8", "err sticky", 32'(rsp_err), 1);
        finish_run;
    end
endmodule